// File: doc/BRIEF.md
# RF Front-End Register-Zero Serial Slave

This block is the receive side of a slave on a two-wire RF front-end control bus. The bus has one serial clock, driven only by the master, and one data line. The block receives the short frame that writes register zero. A frame opens with a sequence start condition. A 4-bit slave address follows, then a command bit, then seven payload bits, then an odd parity bit, and the frame closes with one bus-park clock. The payload is committed to register zero at the falling clock edge of the park cycle. The write happens only when the address equals the configured slave address, the command bit is 1 and the parity check passes. Any other frame leaves the register untouched. The slave then returns to idle and waits for the next start condition.

The bus pins are oversampled by a faster local clock `clk`. Each pin passes through its own synchronizer, and edges are found by comparing the synchronized level with its value one cycle earlier. Data is taken when the bus clock falls. The master changes data while the bus clock is high. The interface-supply input `vio` is an asynchronous, active-low reset. While it is low, register zero holds its default value and the receiver is idle. The data pin is treated as an input only: this block never drives the line.

The controller has seven named states: IDLE, SSC_ARM, ADDR, CMD, DATA, PARITY and PARK. Its transitions are:
- IDLE→SSC_ARM: data rises while the bus clock is low.
- SSC_ARM→IDLE: the bus clock rises.
- SSC_ARM→ADDR: data falls while the bus clock is low.
- ADDR→CMD or ADDR→IDLE: taken at the fourth address bit, on an address match or a mismatch.
- CMD→DATA or CMD→IDLE: command bit 1 or command bit 0.
- DATA→PARITY: after the seventh payload bit.
- PARITY→PARK: after the parity bit.
- PARK→IDLE: at the park falling edge, with a commit when the parity is good.

Top module: `rffe_reg0_slave`

## Requirements
- R1: While `vio` is low, `reg0_q` equals RESET_VAL (default 7'h00) and `reg0_wr` is 0. The reset takes effect at once, without waiting for a `clk` edge.
- R2: A frame is accepted only after a start condition: `sdata` rises and then falls while `sclk` stays low. Clock pulses that are not preceded by a start condition cause no write.
- R3: The four address bits arrive MSB first and are compared with SLAVE_ADDR (default 4'h5). On a mismatch the frame is dropped, and the slave returns to idle.
- R4: The bit after the address must be 1 (the register-zero write command). A 0 drops the frame.
- R5: The seven payload bits arrive D6 first. Parity is odd: the count of ones across the address, command, payload and parity bits must be odd. Otherwise the write is discarded.
- R6: The write happens at the falling `sclk` edge of the park cycle that follows the parity bit, and not before. `reg0_wr` is high for exactly one `clk` cycle, in the same cycle that `reg0_q` takes the payload. `reg0_q` changes in no other cycle.
- R7: Each bit is sampled on a falling `sclk` edge. Changes on `sdata` while `sclk` is high do not disturb the frame.
- R8: After any frame, whether written or discarded, the slave accepts the next start condition. Back-to-back frames each take effect.
- R9: If `sclk` rises after the data rise of a start condition but before its data fall, the start condition is abandoned and the frame that follows is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| vio | input | 1 | Interface supply present; low = asynchronous reset |
| sclk | input | 1 | Bus serial clock from the master |
| sdata | input | 1 | Bus serial data (received only) |
| reg0_q | output | DATA_W | Register zero contents |
| reg0_wr | output | 1 | One-cycle pulse when register zero is written |

## Verification
The embedded assertions check the following on every cycle:
- `reg0_wr` is a single-cycle pulse.
- `reg0_q` never moves except with that pulse.
- The pulse only follows the PARK state and leaves the controller in IDLE.
- The command state is entered only from address reception.
- The shift register only moves on a sampled bit or a frame clear.

Only the directed scenarios can show the rest, because each depends on whole frames sent on the bus pins: which frames are accepted, meaning correct address, command bit, odd parity and a well-formed start condition; that nothing is written before the park edge; and that `vio` resets the register immediately.

// File: rtl/rffe_pkg.sv
package rffe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSC_ARM,
        ST_ADDR,
        ST_CMD,
        ST_DATA,
        ST_PARITY,
        ST_PARK
    } rx_state_t;

endpackage

// File: rtl/rffe_bus_sampler.sv
module rffe_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdata_i,
    output logic sclk_lvl,
    output logic sdata_lvl,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdata_rise,
    output logic sdata_fall
);

    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] sclk_pipe;
    logic [DEPTH-1:0] sdata_pipe;
    logic             sclk_prev;
    logic             sdata_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe  <= '0;
            sdata_pipe <= '0;
            sclk_prev  <= 1'b0;
            sdata_prev <= 1'b0;
        end else begin
            sclk_pipe  <= {sclk_pipe[DEPTH-2:0], sclk_i};
            sdata_pipe <= {sdata_pipe[DEPTH-2:0], sdata_i};
            sclk_prev  <= sclk_pipe[DEPTH-1];
            sdata_prev <= sdata_pipe[DEPTH-1];
        end
    end

    assign sclk_lvl   = sclk_pipe[DEPTH-1];
    assign sdata_lvl  = sdata_pipe[DEPTH-1];
    assign sclk_rise  = sclk_lvl & ~sclk_prev;
    assign sclk_fall  = ~sclk_lvl & sclk_prev;
    assign sdata_rise = sdata_lvl & ~sdata_prev;
    assign sdata_fall = ~sdata_lvl & sdata_prev;

endmodule

// File: rtl/rffe_frame_shift.sv
module rffe_frame_shift #(
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] bits_q,
    output logic             odd_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            odd_q  <= 1'b0;
        end else if (clear) begin
            bits_q <= '0;
            odd_q  <= 1'b0;
        end else if (shift_en) begin
            bits_q <= {bits_q[WIDTH-2:0], bit_in};
            odd_q  <= odd_q ^ bit_in;
        end
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift_en) |=> ($stable(bits_q) && $stable(odd_q))); // R7

endmodule

// File: rtl/rffe_reg0_slave.sv
module rffe_reg0_slave
    import rffe_pkg::*;
#(
    parameter int              ADDR_W     = 4,
    parameter int              DATA_W     = 7,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 4'h5,
    parameter logic [DATA_W-1:0] RESET_VAL  = 7'h00
) (
    input  logic              clk,
    input  logic              vio,
    input  logic              sclk,
    input  logic              sdata,
    output logic [DATA_W-1:0] reg0_q,
    output logic              reg0_wr
);

    localparam int FRAME_W   = ADDR_W + 1 + DATA_W + 1;
    localparam int FIELD_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W     = $clog2(FIELD_MAX) + 1;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    logic sclk_lvl, sdata_lvl, sclk_rise, sclk_fall, sdata_rise, sdata_fall;

    rffe_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (vio),
        .sclk_i     (sclk),
        .sdata_i    (sdata),
        .sclk_lvl   (sclk_lvl),
        .sdata_lvl  (sdata_lvl),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .sdata_rise (sdata_rise),
        .sdata_fall (sdata_fall)
    );

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic               shift_en, frame_clr, commit;
    logic [FRAME_W-1:0] bits_q;
    logic               odd_q;
    logic [ADDR_W-1:0]  addr_full;

    rffe_frame_shift #(.WIDTH(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (vio),
        .clear    (frame_clr),
        .shift_en (shift_en),
        .bit_in   (sdata_lvl),
        .bits_q   (bits_q),
        .odd_q    (odd_q)
    );

    assign addr_full = {bits_q[ADDR_W-2:0], sdata_lvl};

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        shift_en  = 1'b0;
        frame_clr = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!sclk_lvl && sdata_rise) state_d = ST_SSC_ARM;
            end
            ST_SSC_ARM: begin
                if (sclk_rise) begin
                    state_d = ST_IDLE;
                end else if (!sclk_lvl && sdata_fall) begin
                    state_d   = ST_ADDR;
                    frame_clr = 1'b1;
                end
            end
            ST_ADDR: begin
                if (sclk_fall) begin
                    shift_en = 1'b1;
                    if (cnt_q == ADDR_LAST)
                        state_d = (addr_full == SLAVE_ADDR) ? ST_CMD : ST_IDLE;
                end
            end
            ST_CMD: begin
                if (sclk_fall) begin
                    shift_en = 1'b1;
                    state_d  = sdata_lvl ? ST_DATA : ST_IDLE;
                end
            end
            ST_DATA: begin
                if (sclk_fall) begin
                    shift_en = 1'b1;
                    if (cnt_q == DATA_LAST) state_d = ST_PARITY;
                end
            end
            ST_PARITY: begin
                if (sclk_fall) begin
                    shift_en = 1'b1;
                    state_d  = ST_PARK;
                end
            end
            ST_PARK: begin
                if (sclk_fall) begin
                    commit  = odd_q;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and field counter
    always_ff @(posedge clk or negedge vio) begin
        if (!vio) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (sclk_fall && (state_q == ST_ADDR || state_q == ST_DATA))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge vio) begin
        if (!vio) begin
            reg0_q  <= RESET_VAL;
            reg0_wr <= 1'b0;
        end else begin
            reg0_wr <= commit;
            if (commit) reg0_q <= bits_q[DATA_W:1];
        end
    end

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!vio)
        reg0_wr |=> !reg0_wr); // R6

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!vio)
        1'b1 |=> (reg0_wr || $stable(reg0_q))); // R6

    AST_WR_AFTER_PARK: assert property (@(posedge clk) disable iff (!vio)
        reg0_wr |-> ($past(state_q) == ST_PARK && state_q == ST_IDLE)); // R8

    AST_CMD_FROM_ADDR: assert property (@(posedge clk) disable iff (!vio)
        (state_q == ST_CMD && $past(state_q) != ST_CMD) |-> $past(state_q) == ST_ADDR); // R3

endmodule

// File: tb/rffe_reg0_slave_test.sv
`timescale 1ns/1ps
module rffe_reg0_slave_test;

    logic       clk = 1'b0;
    logic       vio = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [6:0] reg0_q;
    logic       reg0_wr;

    int n_vec = 0;
    int n_bad = 0;
    int wr_cnt = 0;

    localparam logic [3:0] MY_ADDR = 4'h5;

    always #5 clk = ~clk;

    rffe_reg0_slave uut (
        .clk     (clk),
        .vio     (vio),
        .sclk    (sclk),
        .sdata   (sdata),
        .reg0_q  (reg0_q),
        .reg0_wr (reg0_wr)
    );

    always @(posedge clk) if (reg0_wr) wr_cnt <= wr_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b);
        sclk = 1'b1;
        #20 sdata = b;
        #60 sclk = 1'b0;
        #80;
    endtask

    task automatic bus_ssc();
        sclk = 1'b0;
        sdata = 1'b1;
        #80 sdata = 1'b0;
        #80;
    endtask

    function automatic logic odd_bit(input logic [3:0] a, input logic c, input logic [6:0] d);
        return ~(^{a, c, d});
    endfunction

    task automatic send_body(input logic [3:0] a, input logic c, input logic [6:0] d,
                             input logic bad_par);
        for (int i = 3; i >= 0; i--) bus_bit(a[i]);
        bus_bit(c);
        for (int i = 6; i >= 0; i--) bus_bit(d[i]);
        bus_bit(odd_bit(a, c, d) ^ bad_par);
    endtask

    task automatic frame(input logic [3:0] a, input logic c, input logic [6:0] d,
                         input logic bad_par);
        bus_ssc();
        send_body(a, c, d, bad_par);
        bus_bit(1'b0);
        #200;
    endtask

    task automatic t_reset();
        #100;
        chk("R1 reset value", reg0_q, 7'h00);
        chk("R1 no write in reset", reg0_wr, 0);
        vio = 1'b1;
        #200;
        chk("R1 value after release", reg0_q, 7'h00);
    endtask

    task automatic t_good_write();
        int w0 = wr_cnt;
        bus_ssc();
        send_body(MY_ADDR, 1'b1, 7'h5A, 1'b0);
        chk("R6 no write before park", reg0_q, 7'h00);
        chk("R6 no strobe before park", wr_cnt - w0, 0);
        bus_bit(1'b0);
        #200;
        chk("R5 R7 payload written", reg0_q, 7'h5A);
        chk("R6 one strobe", wr_cnt - w0, 1);
    endtask

    task automatic t_back_to_back();
        int w0 = wr_cnt;
        frame(MY_ADDR, 1'b1, 7'h23, 1'b0);
        frame(MY_ADDR, 1'b1, 7'h7F, 1'b0);
        chk("R8 second frame value", reg0_q, 7'h7F);
        chk("R8 two strobes", wr_cnt - w0, 2);
        frame(MY_ADDR, 1'b1, 7'h00, 1'b0);
        chk("R8 all-zero payload", reg0_q, 7'h00);
        frame(MY_ADDR, 1'b1, 7'h41, 1'b0);
        chk("R5 D6-first order", reg0_q, 7'h41);
    endtask

    task automatic t_bad_parity();
        int w0 = wr_cnt;
        frame(MY_ADDR, 1'b1, 7'h11, 1'b1);
        chk("R5 bad parity discarded", reg0_q, 7'h41);
        chk("R5 bad parity no strobe", wr_cnt - w0, 0);
        frame(MY_ADDR, 1'b1, 7'h12, 1'b0);
        chk("R8 recover after bad parity", reg0_q, 7'h12);
    endtask

    task automatic t_wrong_addr();
        frame(4'hA, 1'b1, 7'h33, 1'b0);
        chk("R3 mismatched address ignored", reg0_q, 7'h12);
        frame(4'h4, 1'b1, 7'h34, 1'b0);
        chk("R3 neighbour address ignored", reg0_q, 7'h12);
        frame(MY_ADDR, 1'b1, 7'h35, 1'b0);
        chk("R8 recover after mismatch", reg0_q, 7'h35);
    endtask

    task automatic t_cmd_zero();
        frame(MY_ADDR, 1'b0, 7'h66, 1'b0);
        chk("R4 command 0 ignored", reg0_q, 7'h35);
    endtask

    task automatic t_no_ssc();
        send_body(MY_ADDR, 1'b1, 7'h2C, 1'b0);
        bus_bit(1'b0);
        #200;
        chk("R2 no start condition ignored", reg0_q, 7'h35);
    endtask

    task automatic t_abort_ssc();
        sclk = 1'b0;
        sdata = 1'b1;
        #80 sclk = 1'b1;
        #80 sclk = 1'b0;
        #40 sdata = 1'b0;
        #80;
        send_body(MY_ADDR, 1'b1, 7'h19, 1'b0);
        bus_bit(1'b0);
        #200;
        chk("R9 abandoned start ignored", reg0_q, 7'h35);
        frame(MY_ADDR, 1'b1, 7'h5A, 1'b0);
        chk("R2 valid start accepted", reg0_q, 7'h5A);
    endtask

    task automatic t_async_reset();
        @(posedge clk);
        #2 vio = 1'b0;
        #1;
        chk("R1 immediate reset", reg0_q, 7'h00);
        #100 vio = 1'b1;
        #100;
        frame(MY_ADDR, 1'b1, 7'h6B, 1'b0);
        chk("R1 usable after reset", reg0_q, 7'h6B);
    endtask

    initial begin
        t_reset();
        t_good_write();
        t_back_to_back();
        t_bad_parity();
        t_wrong_addr();
        t_cmd_zero();
        t_no_ssc();
        t_abort_ssc();
        t_async_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule